// File: doc/BRIEF.md
# Multiplexed-Bus Mailbox Interrupt Slave

This block is the host-facing end of a one-byte mailbox. A host processor reaches it over an 8-bit bus that carries first an address and then data on the same wires. A second agent, on the signal-processing side of the chip, posts a command byte into the mailbox. Posting the byte sets a pending flag, and that flag raises an interrupt to the host unless the host has masked it. The host then either reads the mailbox, which consumes the command and drops the flag, or runs an acknowledge cycle, in which the block answers with a programmable vector byte on the shared bus.

Every host strobe is asynchronous to the block clock. Each one passes through a two-stage synchroniser before its edges are detected. The block does not drive a bidirectional pin itself. It supplies the outgoing byte and an output-enable, and the pad ring builds the tri-state driver from them.

Top module: `mbx_irq_slave`

## Requirements
- R1: The address is taken from `ad_i` when the synchronised `ale_i` falls. The register map is: 0x00 mailbox command, 0x01 control (bit 0 = MASK), 0x02 interrupt vector, 0x03 status (bit 0 = busy, all other bits 0). Any other address reads as 0x00.
- R2: A read starts only if `ale_i` is already low when `rdcs_n_i` falls. If `rdcs_n_i` falls while `ale_i` is high, the bus is not driven and the busy flag is not cleared.
- R3: During a recognised read, `ad_oe_o` is 1 and `ad_o` carries the value the addressed register held when the read began.
- R4: After `rdcs_n_i` returns high, `ad_oe_o` returns to 0.
- R5: A one-cycle `dsp_wr_i` pulse loads `dsp_cmd_i` into the mailbox command register and sets the busy flag at the next clock edge.
- R6: `irq_o` follows the busy flag with no register in between whenever MASK is 0.
- R7: While MASK is 1, `irq_o` is 0. The busy flag keeps its value and can still be seen in status bit 0.
- R8: While `iack_n_i` is low, `ad_oe_o` is 1 and `ad_o` carries the vector register. This overrides the data of any read in progress.
- R9: A recognised read of address 0x00 clears the busy flag, and `irq_o` falls with it. If `dsp_wr_i` arrives in the same cycle, the set wins.
- R10: After reset, the command, control and vector registers are 0x00, busy is 0, `irq_o` is 0 and `ad_oe_o` is 0.
- R11: A host write captures `ad_i` when the synchronised `wrcs_n_i` falls after the address phase. Only control (0x01) and vector (0x02) are writable. Writes to 0x00, 0x03 or unmapped addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ale_i | input | 1 | Address-latch-enable strobe, active high, asynchronous |
| rdcs_n_i | input | 1 | Combined read/chip-select strobe, active low, asynchronous |
| wrcs_n_i | input | 1 | Combined write/chip-select strobe, active low, asynchronous |
| iack_n_i | input | 1 | Interrupt acknowledge, active low, asynchronous |
| ad_i | input | DATA_W | Incoming multiplexed address/data byte |
| ad_o | output | DATA_W | Outgoing data byte for the pad driver |
| ad_oe_o | output | 1 | Output enable of the pad driver |
| dsp_wr_i | input | 1 | Single-cycle mailbox write from the DSP side, synchronous |
| dsp_cmd_i | input | DATA_W | Command byte for the mailbox |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
The bench drops the read strobe while the address strobe is still high and expects the bus to stay undriven with the interrupt still pending. A design that ignored the address phase would drive the bus and silently swallow a command. It sets the mask while a command is pending and expects the interrupt to fall while the status bit stays at 1. A design that cleared busy on masking would lose the command once the mask is lifted. It raises acknowledge in the middle of a register read and expects the vector to replace the read data and the read data to come back afterwards, which exposes a wrong priority in the output mux. It also writes to the read-only addresses and expects no change, and it checks that the output enable drops after each cycle, so a block that kept driving the bus would be caught.

// File: rtl/mbx_pkg.sv
// Package mbx_pkg
// Shared constants and the register-select type for the mailbox slave.
// Assumes the host address space decodes at full bus width.
package mbx_pkg;

    localparam int unsigned ADR_CMD  = 0;
    localparam int unsigned ADR_CTRL = 1;
    localparam int unsigned ADR_VEC  = 2;
    localparam int unsigned ADR_STAT = 3;

    localparam int unsigned CTRL_MASK_BIT = 0;
    localparam int unsigned STAT_BUSY_BIT = 0;

    // Index of each strobe in the synchroniser bank
    localparam int unsigned STB_ALE  = 0;
    localparam int unsigned STB_RD   = 1;
    localparam int unsigned STB_WR   = 2;
    localparam int unsigned STB_IACK = 3;
    localparam int unsigned STB_NUM  = 4;

    typedef enum logic [2:0] {
        SEL_CMD,
        SEL_CTRL,
        SEL_VEC,
        SEL_STAT,
        SEL_NONE
    } reg_sel_e;

endpackage

// File: rtl/mbx_sync.sv
// Module mbx_sync
// Brings one asynchronous strobe into the clock domain through STAGES
// flops and gives single-cycle pulses on its falling and rising edges.
// Assumes STAGES >= 2. RST_VAL is the idle level of the strobe.
module mbx_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o,
    output logic fell_o,
    output logic rose_o
);

    logic [STAGES-1:0] sh_q;
    logic              prev_q;

    // Shift the raw strobe through the chain and keep one delayed copy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q   <= {STAGES{RST_VAL}};
            prev_q <= RST_VAL;
        end else begin
            sh_q   <= {sh_q[STAGES-2:0], d_i};
            prev_q <= sh_q[STAGES-1];
        end
    end

    // Level and edge outputs
    always_comb begin
        q_o    = sh_q[STAGES-1];
        fell_o = prev_q & ~sh_q[STAGES-1];
        rose_o = ~prev_q & sh_q[STAGES-1];
    end

endmodule

// File: rtl/mbx_busif.sv
// Module mbx_busif
// Host bus sequencer. It latches the address when the address strobe falls,
// qualifies read and write cycles against the address phase, snapshots the
// read data, and steers either that snapshot or the vector onto the bus.
// Assumes strobes arrive already synchronised. ad_i is stable whenever a
// synchronised strobe edge is used.
module mbx_busif
    import mbx_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ale_s,
    input  logic              ale_fell,
    input  logic              rd_n_s,
    input  logic              rd_fell,
    input  logic              wr_fell,
    input  logic              iack_n_s,
    input  logic [DATA_W-1:0] ad_i,
    input  logic [DATA_W-1:0] rd_value,
    input  logic [DATA_W-1:0] vec,
    output reg_sel_e          sel,
    output logic              rd_start,
    output logic              wr_start,
    output logic              iack_act,
    output logic [DATA_W-1:0] ad_o,
    output logic              ad_oe_o
);

    logic [DATA_W-1:0] addr_q;
    logic [DATA_W-1:0] snap_q;
    logic              rd_act_q;

    // Capture the address at the end of the address phase
    always_ff @(posedge clk) begin
        if (!rst_n) addr_q <= '0;
        else if (ale_fell) addr_q <= ad_i;
    end

    // Decode the latched address into a register select
    always_comb begin
        if (addr_q == DATA_W'(ADR_CMD))       sel = SEL_CMD;
        else if (addr_q == DATA_W'(ADR_CTRL)) sel = SEL_CTRL;
        else if (addr_q == DATA_W'(ADR_VEC))  sel = SEL_VEC;
        else if (addr_q == DATA_W'(ADR_STAT)) sel = SEL_STAT;
        else                                  sel = SEL_NONE;
    end

    // Accept data strobes only after the address strobe is low
    always_comb begin
        rd_start = rd_fell & ~ale_s;
        wr_start = wr_fell & ~ale_s;
        iack_act = ~iack_n_s;
    end

    // Track the read cycle and hold the data picked at its start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_act_q <= 1'b0;
            snap_q   <= '0;
        end else begin
            if (rd_start) begin
                rd_act_q <= 1'b1;
                snap_q   <= rd_value;
            end else if (rd_n_s) begin
                rd_act_q <= 1'b0;
            end
        end
    end

    // Bus output mux: the acknowledge vector wins over read data
    always_comb begin
        ad_oe_o = rd_act_q | iack_act;
        if (iack_act)      ad_o = vec;
        else if (rd_act_q) ad_o = snap_q;
        else               ad_o = '0;
    end

endmodule

// File: rtl/mbx_regs.sv
// Module mbx_regs
// Register file of the mailbox: command byte, control, vector and busy flag.
// Assumes the write and clear strobes are single-cycle pulses. When a set
// and a clear of the busy flag coincide, the set wins.
module mbx_regs
    import mbx_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dsp_wr,
    input  logic [DATA_W-1:0] dsp_cmd,
    input  reg_sel_e          sel,
    input  logic              busy_clr,
    input  logic              wr_start,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_value,
    output logic              busy,
    output logic              mask,
    output logic [DATA_W-1:0] vec
);

    logic [DATA_W-1:0] cmd_q;
    logic [DATA_W-1:0] ctrl_q;
    logic [DATA_W-1:0] vec_q;
    logic              busy_q;

    // Mailbox command byte and its busy flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q  <= '0;
            busy_q <= 1'b0;
        end else begin
            if (dsp_wr) begin
                cmd_q  <= dsp_cmd;
                busy_q <= 1'b1;
            end else if (busy_clr) begin
                busy_q <= 1'b0;
            end
        end
    end

    // Host-writable control and vector registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            vec_q  <= '0;
        end else if (wr_start) begin
            if (sel == SEL_CTRL) ctrl_q <= wr_data;
            if (sel == SEL_VEC)  vec_q  <= wr_data;
        end
    end

    // Read mux over the register map
    always_comb begin
        rd_value = '0;
        case (sel)
            SEL_CMD:  rd_value = cmd_q;
            SEL_CTRL: rd_value = ctrl_q;
            SEL_VEC:  rd_value = vec_q;
            SEL_STAT: rd_value[STAT_BUSY_BIT] = busy_q;
            default:  rd_value = '0;
        endcase
    end

    // Expose state to the interrupt logic and the bus mux
    always_comb begin
        busy = busy_q;
        mask = ctrl_q[CTRL_MASK_BIT];
        vec  = vec_q;
    end

endmodule

// File: rtl/mbx_irq_slave.sv
// Module mbx_irq_slave
// Top of the mailbox interrupt slave. It synchronises the host strobes,
// runs the bus sequencer and the register file, and forms the maskable
// interrupt straight from the busy flag.
// Assumes dsp_wr_i and dsp_cmd_i are synchronous to clk.
module mbx_irq_slave
    import mbx_pkg::*;
#(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ale_i,
    input  logic              rdcs_n_i,
    input  logic              wrcs_n_i,
    input  logic              iack_n_i,
    input  logic [DATA_W-1:0] ad_i,
    output logic [DATA_W-1:0] ad_o,
    output logic              ad_oe_o,
    input  logic              dsp_wr_i,
    input  logic [DATA_W-1:0] dsp_cmd_i,
    output logic              irq_o
);

    localparam logic [STB_NUM-1:0] STB_IDLE = 4'b1110;

    logic [STB_NUM-1:0] stb_raw;
    logic [STB_NUM-1:0] stb_q;
    logic [STB_NUM-1:0] stb_fell;
    logic [STB_NUM-1:0] stb_rose;

    reg_sel_e          sel;
    logic              rd_start;
    logic              wr_start;
    logic              iack_act;
    logic              mbox_rd_clr;
    logic [DATA_W-1:0] rd_value;
    logic              busy;
    logic              mask;
    logic [DATA_W-1:0] vec_q;

    // Gather the strobes into one bank
    always_comb begin
        stb_raw           = '0;
        stb_raw[STB_ALE]  = ale_i;
        stb_raw[STB_RD]   = rdcs_n_i;
        stb_raw[STB_WR]   = wrcs_n_i;
        stb_raw[STB_IACK] = iack_n_i;
    end

    // One synchroniser per strobe, reset to its idle level
    generate
        for (genvar g = 0; g < STB_NUM; g++) begin : g_sync
            mbx_sync #(
                .STAGES  (SYNC_STAGES),
                .RST_VAL (STB_IDLE[g])
            ) u_sync (
                .clk    (clk),
                .rst_n  (rst_n),
                .d_i    (stb_raw[g]),
                .q_o    (stb_q[g]),
                .fell_o (stb_fell[g]),
                .rose_o (stb_rose[g])
            );
        end
    endgenerate

    mbx_busif #(.DATA_W(DATA_W)) u_busif (
        .clk      (clk),
        .rst_n    (rst_n),
        .ale_s    (stb_q[STB_ALE]),
        .ale_fell (stb_fell[STB_ALE]),
        .rd_n_s   (stb_q[STB_RD]),
        .rd_fell  (stb_fell[STB_RD]),
        .wr_fell  (stb_fell[STB_WR]),
        .iack_n_s (stb_q[STB_IACK]),
        .ad_i     (ad_i),
        .rd_value (rd_value),
        .vec      (vec_q),
        .sel      (sel),
        .rd_start (rd_start),
        .wr_start (wr_start),
        .iack_act (iack_act),
        .ad_o     (ad_o),
        .ad_oe_o  (ad_oe_o)
    );

    // A recognised read of the mailbox consumes the command
    always_comb mbox_rd_clr = rd_start & (sel == SEL_CMD);

    mbx_regs #(.DATA_W(DATA_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .dsp_wr   (dsp_wr_i),
        .dsp_cmd  (dsp_cmd_i),
        .sel      (sel),
        .busy_clr (mbox_rd_clr),
        .wr_start (wr_start),
        .wr_data  (ad_i),
        .rd_value (rd_value),
        .busy     (busy),
        .mask     (mask),
        .vec      (vec_q)
    );

    // Interrupt comes straight from the busy flag, gated by the mask
    always_comb irq_o = busy & ~mask;

endmodule

// File: rtl/mbx_irq_slave_chk.sv
// Module mbx_irq_slave_chk
// Temporal checks on the mailbox slave, bound into every instance of the top.
// Assumes the signal names of mbx_irq_slave.
module mbx_irq_slave_chk #(
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dsp_wr_i,
    input logic              wr_start,
    input logic              busy,
    input logic              mask,
    input logic              irq_o,
    input logic              iack_act,
    input logic              ad_oe_o,
    input logic [DATA_W-1:0] ad_o,
    input logic [DATA_W-1:0] vec_q,
    input logic              mbox_rd_clr
);

    // R5
    busy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dsp_wr_i |=> busy);

    // R6
    irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dsp_wr_i && !mask && !wr_start) |=> irq_o);

    // R7
    mask_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mask |-> !irq_o);

    // R8
    vec_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iack_act |-> (ad_oe_o && ad_o == vec_q));

    // R9
    rd_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mbox_rd_clr && !dsp_wr_i) |=> (!busy && !irq_o));

endmodule

bind mbx_irq_slave mbx_irq_slave_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .dsp_wr_i    (dsp_wr_i),
    .wr_start    (wr_start),
    .busy        (busy),
    .mask        (mask),
    .irq_o       (irq_o),
    .iack_act    (iack_act),
    .ad_oe_o     (ad_oe_o),
    .ad_o        (ad_o),
    .vec_q       (vec_q),
    .mbox_rd_clr (mbox_rd_clr)
);

// File: tb/mbx_irq_slave_test.sv
`timescale 1ns/1ps
// Directed bench for mbx_irq_slave. Inputs change on the falling clock
// edge and outputs are sampled there too.
module mbx_irq_slave_test;

    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ale = 1'b0;
    logic          rdcs_n = 1'b1;
    logic          wrcs_n = 1'b1;
    logic          iack_n = 1'b1;
    logic [DW-1:0] ad_in = '0;
    logic [DW-1:0] ad_out;
    logic          ad_oe;
    logic          dsp_wr = 1'b0;
    logic [DW-1:0] dsp_cmd = '0;
    logic          irq;

    int n_run  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    mbx_irq_slave #(.DATA_W(DW)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ale_i     (ale),
        .rdcs_n_i  (rdcs_n),
        .wrcs_n_i  (wrcs_n),
        .iack_n_i  (iack_n),
        .ad_i      (ad_in),
        .ad_o      (ad_out),
        .ad_oe_o   (ad_oe),
        .dsp_wr_i  (dsp_wr),
        .dsp_cmd_i (dsp_cmd),
        .irq_o     (irq)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic addr_phase(input logic [DW-1:0] a);
        ad_in = a;
        ale   = 1'b1;
        tick(3);
        ale   = 1'b0;
        tick(4);
    endtask

    task automatic bus_read(input logic [DW-1:0] a, output logic [DW-1:0] d,
                            output logic oe_during, output logic oe_after);
        addr_phase(a);
        ad_in  = '0;
        rdcs_n = 1'b0;
        tick(5);
        d         = ad_out;
        oe_during = ad_oe;
        rdcs_n    = 1'b1;
        tick(5);
        oe_after  = ad_oe;
    endtask

    task automatic bus_write(input logic [DW-1:0] a, input logic [DW-1:0] d);
        addr_phase(a);
        ad_in  = d;
        tick(1);
        wrcs_n = 1'b0;
        tick(5);
        wrcs_n = 1'b1;
        tick(3);
        ad_in  = '0;
        tick(2);
    endtask

    task automatic dsp_post(input logic [DW-1:0] c);
        dsp_cmd = c;
        dsp_wr  = 1'b1;
        tick(1);
        dsp_wr  = 1'b0;
    endtask

    // R10 reset values, R3/R4 basic read timing
    task automatic t_reset;
        logic [DW-1:0] d;
        logic oe1, oe2;
        check("R10 oe", DW'(ad_oe), 8'h00);
        check("R10 irq", DW'(irq), 8'h00);
        bus_read(8'h01, d, oe1, oe2);
        check("R10 ctrl", d, 8'h00);
        check("R3 oe during read", DW'(oe1), 8'h01);
        check("R4 oe after read", DW'(oe2), 8'h00);
        bus_read(8'h02, d, oe1, oe2);
        check("R10 vector", d, 8'h00);
        bus_read(8'h03, d, oe1, oe2);
        check("R10 status", d, 8'h00);
        bus_read(8'h00, d, oe1, oe2);
        check("R10 command", d, 8'h00);
    endtask

    // R1 decode, R11 writable and read-only registers
    task automatic t_regs;
        logic [DW-1:0] d;
        logic oe1, oe2;
        bus_write(8'h02, 8'h5A);
        bus_read(8'h02, d, oe1, oe2);
        check("R11 vector write", d, 8'h5A);
        bus_read(8'h01, d, oe1, oe2);
        check("R1 ctrl distinct", d, 8'h00);
        bus_read(8'h40, d, oe1, oe2);
        check("R1 unmapped reads zero", d, 8'h00);
        bus_write(8'h00, 8'hFF);
        bus_write(8'h03, 8'hFF);
        bus_write(8'h42, 8'hA5);
        bus_read(8'h00, d, oe1, oe2);
        check("R11 command read-only", d, 8'h00);
        bus_read(8'h03, d, oe1, oe2);
        check("R11 status read-only", d, 8'h00);
        check("R11 irq quiet", DW'(irq), 8'h00);
        bus_read(8'h02, d, oe1, oe2);
        check("R11 unmapped write ignored", d, 8'h5A);
    endtask

    // R5 set, R6 raise, R9 consume
    task automatic t_mailbox;
        logic [DW-1:0] d;
        logic oe1, oe2;
        dsp_post(8'h3C);
        check("R6 irq raised", DW'(irq), 8'h01);
        bus_read(8'h03, d, oe1, oe2);
        check("R5 busy in status", d, 8'h01);
        check("R5 status read keeps irq", DW'(irq), 8'h01);
        bus_read(8'h00, d, oe1, oe2);
        check("R3 command data", d, 8'h3C);
        check("R9 irq cleared", DW'(irq), 8'h00);
        bus_read(8'h03, d, oe1, oe2);
        check("R9 busy cleared", d, 8'h00);
    endtask

    // R7 masking keeps busy
    task automatic t_mask;
        logic [DW-1:0] d;
        logic oe1, oe2;
        dsp_post(8'h11);
        bus_write(8'h01, 8'h01);
        check("R7 irq masked", DW'(irq), 8'h00);
        bus_read(8'h03, d, oe1, oe2);
        check("R7 busy kept", d, 8'h01);
        dsp_post(8'h12);
        check("R7 masked new post", DW'(irq), 8'h00);
        bus_write(8'h01, 8'h00);
        check("R6 irq after unmask", DW'(irq), 8'h01);
        bus_read(8'h00, d, oe1, oe2);
        check("R5 latest command", d, 8'h12);
        check("R9 irq cleared", DW'(irq), 8'h00);
    endtask

    // R2 read while address strobe is high is ignored
    task automatic t_addr_phase;
        logic [DW-1:0] d;
        logic oe1, oe2;
        dsp_post(8'h22);
        ad_in  = 8'h00;
        ale    = 1'b1;
        tick(2);
        rdcs_n = 1'b0;
        tick(6);
        check("R2 no drive during address phase", DW'(ad_oe), 8'h00);
        rdcs_n = 1'b1;
        tick(3);
        ale    = 1'b0;
        tick(4);
        check("R2 busy not cleared", DW'(irq), 8'h01);
        bus_read(8'h00, d, oe1, oe2);
        check("R2 later read valid", d, 8'h22);
        check("R9 irq cleared", DW'(irq), 8'h00);
    endtask

    // R8 vector cycle, alone and over a read
    task automatic t_iack;
        iack_n = 1'b0;
        tick(5);
        check("R8 oe on ack", DW'(ad_oe), 8'h01);
        check("R8 vector", ad_out, 8'h5A);
        iack_n = 1'b1;
        tick(5);
        check("R8 released", DW'(ad_oe), 8'h00);
        bus_write(8'h01, 8'h80);
        addr_phase(8'h01);
        ad_in  = '0;
        rdcs_n = 1'b0;
        tick(5);
        check("R3 ctrl read", ad_out, 8'h80);
        iack_n = 1'b0;
        tick(5);
        check("R8 vector overrides read", ad_out, 8'h5A);
        iack_n = 1'b1;
        tick(5);
        check("R3 read data back", ad_out, 8'h80);
        rdcs_n = 1'b1;
        tick(5);
        check("R4 oe after read", DW'(ad_oe), 8'h00);
    endtask

    initial begin
        tick(5);
        rst_n = 1'b1;
        tick(2);
        t_reset;
        t_regs;
        t_mailbox;
        t_mask;
        t_addr_phase;
        t_iack;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule